// File: doc/BRIEF.md
# Bidirectional Address Stepper for RAM March Tests

This block produces the address stream for a March-style memory self-test. It is a W-bit linear feedback shift register with a zero-insertion term in its feedback, so it walks all 2^W addresses, including all-zeros, once per period. A direction control sets the shift direction. Each stage has a 2:1 multiplexer that takes its bit from the neighbour above or below, and one of two feedback networks supplies the bit that enters. Stepping down undoes stepping up exactly. One generator therefore serves both the ascending and the descending elements of a March algorithm. A controller holds `clear` to start an element at address 0, pulses or holds `step_en` to advance, and watches `wrap` to learn when the element has covered the whole array.

The upward step shifts the register toward bit 0. The entering most significant bit is computed from a primitive feedback polynomial. For W = 3 that polynomial is x^3 + x + 1, and the downward direction uses its reciprocal x^3 + x^2 + 1. Memory access, March sequencing and response checking are handled outside this block. All pins are plain control and status pins. The address is a continuously valid output with no handshake, and `step_en` is the only flow control.

Top module: `bidir_lfsr_addr`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `addr` is 0 and `wrap` is 0.
- R2: A cycle with `clear` high sets `addr` to 0 at the next edge, whatever the values of `step_en` and `dir_down`. `wrap` is 0 after a clear.
- R3: With `step_en` low and `clear` low, `addr` holds its value and `wrap` is 0 after the edge.
- R4: An upward step (`dir_down`=0) sets addr[W-2:0] to the old addr[W-1:1]. For W = 3, starting from 0, the addresses written as binary MSB-first are 000, 100, 110, 111, 011, 101, 010, 001, and then 000 again.
- R5: For every W from 3 to 8, 2^W consecutive upward steps visit every W-bit value exactly once.
- R6: A downward step (`dir_down`=1) sets addr[W-1:1] to the old addr[W-2:0]. It returns the unique value whose upward step gives the current address. For W = 3, starting from 000, it gives 001, 010, 101, 011, 111, 110, 100, 000.
- R7: `wrap` is 1 for exactly the one cycle that follows a step, in either direction, that lands on 0. At all other times it is 0.
- R8: `clear` takes priority over a step requested in the same cycle.
- R9: The direction may change on any cycle. Each step follows the `dir_down` value sampled at its own edge, and no cycle is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_en | input | 1 | Advance one address this cycle |
| dir_down | input | 1 | 0: step up, 1: step down (reverse sequence) |
| clear | input | 1 | Synchronous load of address 0, overrides stepping |
| addr | output | W | Current address |
| wrap | output | 1 | One-cycle pulse after a step lands on address 0 |

## Verification
The assertions assume only that `rst_n` is applied before the first check and that W is at least 3, which gives a period of at least 8. With a period that long, two successive steps can never both land on 0. The random stimulus keeps W between 3 and 8 and holds reset until after several edges. It draws `step_en`, `dir_down` and `clear` independently on every cycle, so clears in either direction, hold cycles and direction reversals all fall inside the assumed envelope. A bench model predicts the address for every width each cycle. It derives the downward step by searching for the predecessor under the upward rule, not by mirroring the hardware.

// File: rtl/bidir_lfsr_pkg.sv
package bidir_lfsr_pkg;

  localparam int unsigned MIN_W = 2;
  localparam int unsigned MAX_W = 16;

  // Primitive feedback masks: bit k set means stage k feeds the XOR.
  function automatic logic [31:0] tap_mask(input int unsigned w);
    logic [31:0] m;
    case (w)
      2:       m = 32'h0000_0003;
      3:       m = 32'h0000_0006;
      4:       m = 32'h0000_000C;
      5:       m = 32'h0000_0014;
      6:       m = 32'h0000_0030;
      7:       m = 32'h0000_0060;
      8:       m = 32'h0000_00B8;
      9:       m = 32'h0000_0110;
      10:      m = 32'h0000_0240;
      11:      m = 32'h0000_0500;
      12:      m = 32'h0000_0829;
      13:      m = 32'h0000_100D;
      14:      m = 32'h0000_2015;
      15:      m = 32'h0000_6000;
      16:      m = 32'h0000_D008;
      default: m = 32'h0000_0000;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/lfsr_fb_net.sv
module lfsr_fb_net #(
  parameter int unsigned W             = 3,
  parameter bit          ENTER_AT_LSB  = 1'b1
) (
  input  logic [W-1:0] cur,
  output logic         fb
);
  import bidir_lfsr_pkg::*;

  localparam logic [31:0]  MASK_FULL = tap_mask(W);
  localparam logic [W-1:0] TAPS      = MASK_FULL[W-1:0];

  generate
    if (ENTER_AT_LSB) begin : g_toward_msb
      // Downward step: new bit enters at bit 0.
      logic zero_low;
      assign zero_low = ~|cur[W-2:0];
      assign fb       = (^(cur & TAPS)) ^ zero_low;
    end else begin : g_toward_lsb
      // Upward step: recovers the bit a downward step would have dropped.
      logic zero_high;
      assign zero_high = ~|cur[W-1:1];
      assign fb        = cur[0] ^ (^(cur[W-1:1] & TAPS[W-2:0])) ^ zero_high;
    end
  endgenerate

endmodule

// File: rtl/lfsr_shift_core.sv
module lfsr_shift_core #(
  parameter int unsigned W = 3
) (
  input  logic [W-1:0] cur,
  input  logic         dir_down,
  input  logic         fb_up,
  input  logic         fb_dn,
  output logic [W-1:0] nxt
);
  localparam int unsigned TOP = W - 1;

  generate
    for (genvar i = 0; i < W; i++) begin : g_stage
      logic from_below;
      logic from_above;
      if (i == 0) begin : g_low_end
        assign from_below = fb_dn;
      end else begin : g_low_mid
        assign from_below = cur[i-1];
      end
      if (i == TOP) begin : g_high_end
        assign from_above = fb_up;
      end else begin : g_high_mid
        assign from_above = cur[i+1];
      end
      assign nxt[i] = dir_down ? from_below : from_above;
    end
  endgenerate

endmodule

// File: rtl/bidir_lfsr_addr.sv
module bidir_lfsr_addr #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_en,
  input  logic         dir_down,
  input  logic         clear,
  output logic [W-1:0] addr,
  output logic         wrap
);
  logic [W-1:0] state_q;
  logic [W-1:0] stepped;
  logic         fb_up;
  logic         fb_dn;
  logic         wrap_q;

  lfsr_fb_net #(.W(W), .ENTER_AT_LSB(1'b0)) u_fb_up (
    .cur (state_q),
    .fb  (fb_up)
  );

  lfsr_fb_net #(.W(W), .ENTER_AT_LSB(1'b1)) u_fb_dn (
    .cur (state_q),
    .fb  (fb_dn)
  );

  lfsr_shift_core #(.W(W)) u_core (
    .cur      (state_q),
    .dir_down (dir_down),
    .fb_up    (fb_up),
    .fb_dn    (fb_dn),
    .nxt      (stepped)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      wrap_q  <= 1'b0;
    end else if (clear) begin
      state_q <= '0;
      wrap_q  <= 1'b0;
    end else if (step_en) begin
      state_q <= stepped;
      wrap_q  <= (stepped == '0);
    end else begin
      wrap_q  <= 1'b0;
    end
  end

  assign addr = state_q;
  assign wrap = wrap_q;

endmodule

// File: rtl/bidir_lfsr_addr_chk.sv
module bidir_lfsr_addr_chk #(
  parameter int unsigned W = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         step_en,
  input logic         dir_down,
  input logic         clear,
  input logic [W-1:0] addr,
  input logic         wrap
);
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (addr == '0 && !wrap)); // R2

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !clear) |=> ($stable(addr) && !wrap)); // R3

  AST_UP_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !clear && !dir_down) |=> (addr[W-2:0] == $past(addr[W-1:1]))); // R4

  AST_DOWN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !clear && dir_down) |=> (addr[W-1:1] == $past(addr[W-2:0]))); // R6

  AST_WRAP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> (addr == '0)); // R7

  AST_WRAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> !wrap); // R7

  AST_STEP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !clear && addr != '0) |=> (wrap == (addr == '0))); // R7

endmodule

bind bidir_lfsr_addr bidir_lfsr_addr_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .step_en  (step_en),
  .dir_down (dir_down),
  .clear    (clear),
  .addr     (addr),
  .wrap     (wrap)
);

// File: tb/bidir_lfsr_addr_bench.sv
module bidir_lfsr_addr_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_en = 1'b0;
  logic dir_down = 1'b0;
  logic clear = 1'b0;

  logic [7:0] addr_w [3:8];
  logic       wrap_w [3:8];

  logic [7:0] exp_a  [3:8];
  logic       exp_wr [3:8];

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  logic [2:0] a3;
  bidir_lfsr_addr #(.W(3)) u_bidir_lfsr_addr (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .dir_down(dir_down),
    .clear(clear), .addr(a3), .wrap(wrap_w[3])
  );
  assign addr_w[3] = 8'(a3);

  generate
    for (genvar gw = 4; gw <= 8; gw++) begin : gen_w
      logic [gw-1:0] a;
      bidir_lfsr_addr #(.W(gw)) u_dut (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .dir_down(dir_down),
        .clear(clear), .addr(a), .wrap(wrap_w[gw])
      );
      assign addr_w[gw] = 8'(a);
    end
  endgenerate

  function automatic logic [7:0] poly_bits(input int w);
    case (w)
      3: return 8'h06;
      4: return 8'h0C;
      5: return 8'h14;
      6: return 8'h30;
      7: return 8'h60;
      default: return 8'hB8;
    endcase
  endfunction

  // Upward rule from R4: shift toward bit 0, new MSB from feedback.
  function automatic logic [7:0] up_next(input int w, input logic [7:0] s);
    logic [7:0] hi;
    logic [7:0] p;
    logic       b;
    hi = s >> 1;
    p  = poly_bits(w);
    b  = s[0];
    for (int k = 0; k < w - 1; k++) if (p[k]) b = b ^ hi[k];
    if (hi == 8'h00) b = ~b;
    return hi | (8'(b) << (w - 1));
  endfunction

  // Downward rule from R6: the predecessor under the upward rule.
  function automatic logic [7:0] dn_prev(input int w, input logic [7:0] s);
    for (int y = 0; y < (1 << w); y++)
      if (up_next(w, 8'(y)) == s) return 8'(y);
    return 8'hFF;
  endfunction

  task automatic check(input bit ok, input string req, input int w,
                       input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s W=%0d got %0h expected %0h", req, w, act, expv);
    end
  endtask

  task automatic compare_all(input string req);
    for (int w = 3; w <= 8; w++) begin
      check(addr_w[w] == exp_a[w], req, w, addr_w[w], exp_a[w]);
      check(wrap_w[w] == exp_wr[w], "R7", w, wrap_w[w], exp_wr[w]);
    end
  endtask

  // Called at a negedge; drives inputs, predicts the edge, samples at next negedge.
  task automatic cyc(input logic en, input logic dr, input logic cl, input string req);
    logic [7:0] n;
    step_en = en; dir_down = dr; clear = cl;
    @(posedge clk);
    for (int w = 3; w <= 8; w++) begin
      if (cl) n = 8'h00;
      else if (en) n = dr ? dn_prev(w, exp_a[w]) : up_next(w, exp_a[w]);
      else n = exp_a[w];
      exp_wr[w] = !cl && en && (n == 8'h00);
      exp_a[w]  = n;
    end
    @(negedge clk);
    compare_all(req);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int seen [3:8][256];
    logic [7:0] up3 [8];
    logic [7:0] dn3 [8];
    logic en, dr, cl;
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5EED_1234);
    up3 = '{8'h4, 8'h6, 8'h7, 8'h3, 8'h5, 8'h2, 8'h1, 8'h0};
    dn3 = '{8'h1, 8'h2, 8'h5, 8'h3, 8'h7, 8'h6, 8'h4, 8'h0};
    for (int w = 3; w <= 8; w++) begin
      exp_a[w] = 8'h00; exp_wr[w] = 1'b0;
      for (int v = 0; v < 256; v++) seen[w][v] = 0;
    end

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1");

    // R4, R5: full upward traversal
    for (int i = 0; i < 256; i++) begin
      cyc(1'b1, 1'b0, 1'b0, "R4");
      if (i < 8) check(addr_w[3] == up3[i], "R4", 3, addr_w[3], up3[i]);
      for (int w = 3; w <= 8; w++) seen[w][addr_w[w]]++;
    end
    for (int w = 3; w <= 8; w++) begin
      bit even = 1'b1;
      for (int v = 0; v < (1 << w); v++) if (seen[w][v] != (256 >> w)) even = 1'b0;
      check(even, "R5", w, 0, 0);
    end

    // R6: full downward traversal from 0
    for (int i = 0; i < 256; i++) begin
      cyc(1'b1, 1'b1, 1'b0, "R6");
      if (i < 8) check(addr_w[3] == dn3[i], "R6", 3, addr_w[3], dn3[i]);
    end

    // R3: hold
    repeat (5) cyc(1'b1, 1'b0, 1'b0, "R4");
    repeat (3) cyc(1'b0, 1'b0, 1'b0, "R3");
    repeat (2) cyc(1'b0, 1'b1, 1'b0, "R3");

    // R2 and R8: clear with and without a step request
    cyc(1'b0, 1'b0, 1'b1, "R2");
    repeat (4) cyc(1'b1, 1'b1, 1'b0, "R6");
    cyc(1'b1, 1'b1, 1'b1, "R8");
    repeat (4) cyc(1'b1, 1'b0, 1'b0, "R4");
    cyc(1'b1, 1'b0, 1'b1, "R8");

    // R9: alternate direction every cycle
    repeat (6) begin
      cyc(1'b1, 1'b0, 1'b0, "R9");
      cyc(1'b1, 1'b1, 1'b0, "R9");
    end

    // R9: constrained random mix
    dr = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      en = ($urandom % 4) != 0;
      if (($urandom % 8) == 0) dr = ~dr;
      cl = ($urandom % 40) == 0;
      cyc(en, dr, cl, "R9");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule